// File: doc/BRIEF.md
# Channel-Masked Dual Register Bank

This block is the control-register store of a two-channel tone synthesizer. Each channel owns a frequency tuning word and a phase offset word. Both words are reached through one shared bus address each. A channel-select register chooses which channels a write actually lands in. That register holds one enable bit per channel. Setting both bits lets one bus write program both channels at once. Setting a single bit lets software give each channel its own value.

Data writes fill a shadow copy of each word. The values on the channel outputs only change when the update input pulses. At that point every shadow copy moves to its active register in the same clock. Software can therefore prepare distinct settings for both channels and make them take effect together. The channel-select register is different: it takes effect as soon as it is written and needs no update.

Top module: `dual_chan_regs`

## Requirements
- R1: During and right after reset, both channel-enable bits are 1, and every shadow and active tuning and phase word is 0.
- R2: A write to address 0x00 loads the enable mask from the low data bits, with bit i selecting channel i. Reading address 0x00 returns the mask zero-extended.
- R3: A write to address 0x04 loads the low 32 data bits into the tuning shadow of every enabled channel. Channels that are not enabled keep their value.
- R4: A write to address 0x05 loads the low 14 data bits into the phase shadow of every enabled channel. The upper data bits are ignored, and channels that are not enabled keep their value.
- R5: A write to 0x04 or 0x05 while no channel is enabled changes no shadow, active or read value.
- R6: Reading 0x04 or 0x05 returns the shadow word of the lowest-numbered enabled channel, zero-extended. With both channels enabled this is channel 0. With no channel enabled the read returns 0.
- R7: Active outputs hold their value in every cycle without an update pulse. An update pulse copies all shadow words to the active outputs, which are visible after that clock edge.
- R8: When an update pulse and a data write share a clock edge, the active registers take the shadow value from before the write, and the write lands in the shadow.
- R9: Writes to addresses other than 0x00, 0x04 and 0x05 change no state. Reads of any other address return 0.
- R10: A new enable mask steers the very next data write and read, with no update pulse in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for one cycle |
| wrAddr | input | 8 | Write address |
| wrData | input | 32 | Write data |
| rdAddr | input | 8 | Read address |
| rdData | output | 32 | Read data, combinational from rdAddr and current state |
| updatePulse | input | 1 | Copies all shadow words to the active outputs |
| tuneActive | output | 64 | Active tuning words; channel i occupies bits [32i+31:32i] |
| phaseActive | output | 28 | Active phase words; channel i occupies bits [14i+13:14i] |

## Verification
The bench runs the per-channel programming sequence of enabling one channel, writing, switching the mask and writing again. It then issues one update. A design that ignored the mask would leave both channels with the last value. A design that needed an update for the mask would route the second write wrongly. Writes with an empty mask are used to catch a bank that treats an empty mask as "all channels". Read-back with both channels enabled must show channel 0, not channel 1. An update landing on the same edge as a write separates a design that forwards the fresh data straight to the outputs from one that copies the old shadow. A long random stream of mixed writes, reads and updates is then checked against a behavioural model on every clock.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  typedef struct packed {
    logic selWr;
    logic tuneWr;
    logic phaseWr;
    logic update;
  } dcrStrobe_t;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_SEL   = 2'd1,
    RD_TUNE  = 2'd2,
    RD_PHASE = 2'd3
  } dcrRdSel_t;
endpackage

// File: rtl/dcr_ctrl.sv
module dcr_ctrl
  import dcr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int SEL_ADDR   = 8'h00,
  parameter int TUNE_ADDR  = 8'h04,
  parameter int PHASE_ADDR = 8'h05
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              updatePulse,
  output dcrStrobe_t        strobe,
  output dcrRdSel_t         rdSel
);
  localparam logic [ADDR_W-1:0] SelA   = ADDR_W'(SEL_ADDR);
  localparam logic [ADDR_W-1:0] TuneA  = ADDR_W'(TUNE_ADDR);
  localparam logic [ADDR_W-1:0] PhaseA = ADDR_W'(PHASE_ADDR);

  always_comb begin
    strobe.selWr   = wrEn && (wrAddr == SelA);
    strobe.tuneWr  = wrEn && (wrAddr == TuneA);
    strobe.phaseWr = wrEn && (wrAddr == PhaseA);
    strobe.update  = updatePulse;
  end

  always_comb begin
    if (rdAddr == SelA)        rdSel = RD_SEL;
    else if (rdAddr == TuneA)  rdSel = RD_TUNE;
    else if (rdAddr == PhaseA) rdSel = RD_PHASE;
    else                       rdSel = RD_NONE;
  end
endmodule

// File: rtl/dcr_datapath.sv
module dcr_datapath
  import dcr_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int DATA_W  = 32,
  parameter int TUNE_W  = 32,
  parameter int PHASE_W = 14
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dcrStrobe_t                strobe,
  input  logic [DATA_W-1:0]         wrData,
  input  dcrRdSel_t                 rdSel,
  output logic [DATA_W-1:0]         rdData,
  output logic [NUM_CH-1:0]         chanEn,
  output logic [NUM_CH*TUNE_W-1:0]  shadowTune,
  output logic [NUM_CH*PHASE_W-1:0] shadowPhase,
  output logic [NUM_CH*TUNE_W-1:0]  tuneActive,
  output logic [NUM_CH*PHASE_W-1:0] phaseActive
);
  localparam int SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  // enable mask: immediate, no double buffering
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             chanEn <= '1;
    else if (strobe.selWr) chanEn <= wrData[NUM_CH-1:0];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadowTune[g*TUNE_W +: TUNE_W]   <= '0;
        shadowPhase[g*PHASE_W +: PHASE_W] <= '0;
      end else begin
        if (strobe.tuneWr && chanEn[g])
          shadowTune[g*TUNE_W +: TUNE_W] <= wrData[TUNE_W-1:0];
        if (strobe.phaseWr && chanEn[g])
          shadowPhase[g*PHASE_W +: PHASE_W] <= wrData[PHASE_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tuneActive[g*TUNE_W +: TUNE_W]   <= '0;
        phaseActive[g*PHASE_W +: PHASE_W] <= '0;
      end else if (strobe.update) begin
        tuneActive[g*TUNE_W +: TUNE_W]   <= shadowTune[g*TUNE_W +: TUNE_W];
        phaseActive[g*PHASE_W +: PHASE_W] <= shadowPhase[g*PHASE_W +: PHASE_W];
      end
    end
  end

  // lowest enabled channel for read-back
  logic [SEL_W-1:0] rdCh;
  logic             anyEn;
  always_comb begin
    rdCh  = '0;
    anyEn = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (chanEn[i]) begin
        rdCh  = SEL_W'(i);
        anyEn = 1'b1;
      end
    end
  end

  always_comb begin
    rdData = '0;
    case (rdSel)
      RD_SEL:   rdData[NUM_CH-1:0] = chanEn;
      RD_TUNE:  if (anyEn) rdData[TUNE_W-1:0] = shadowTune[rdCh*TUNE_W +: TUNE_W];
      RD_PHASE: if (anyEn) rdData[PHASE_W-1:0] = shadowPhase[rdCh*PHASE_W +: PHASE_W];
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/dual_chan_regs.sv
module dual_chan_regs
  import dcr_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int TUNE_W     = 32,
  parameter int PHASE_W    = 14,
  parameter int SEL_ADDR   = 8'h00,
  parameter int TUNE_ADDR  = 8'h04,
  parameter int PHASE_ADDR = 8'h05
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [DATA_W-1:0]         wrData,
  input  logic [ADDR_W-1:0]         rdAddr,
  output logic [DATA_W-1:0]         rdData,
  input  logic                      updatePulse,
  output logic [NUM_CH*TUNE_W-1:0]  tuneActive,
  output logic [NUM_CH*PHASE_W-1:0] phaseActive
);
  dcrStrobe_t                strobe;
  dcrRdSel_t                 rdSel;
  logic [NUM_CH-1:0]         chanEn;
  logic [NUM_CH*TUNE_W-1:0]  shadowTune;
  logic [NUM_CH*PHASE_W-1:0] shadowPhase;

  dcr_ctrl #(
    .ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR),
    .TUNE_ADDR(TUNE_ADDR), .PHASE_ADDR(PHASE_ADDR)
  ) ctrl_i (
    .wrEn(wrEn), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .updatePulse(updatePulse), .strobe(strobe), .rdSel(rdSel)
  );

  dcr_datapath #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .TUNE_W(TUNE_W), .PHASE_W(PHASE_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .chanEn(chanEn),
    .shadowTune(shadowTune), .shadowPhase(shadowPhase),
    .tuneActive(tuneActive), .phaseActive(phaseActive)
  );
endmodule

// File: rtl/dcr_checker.sv
module dcr_checker #(
  parameter int NUM_CH     = 2,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int TUNE_W     = 32,
  parameter int PHASE_W    = 14,
  parameter int SEL_ADDR   = 8'h00,
  parameter int TUNE_ADDR  = 8'h04,
  parameter int PHASE_ADDR = 8'h05
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      wrEn,
  input logic [ADDR_W-1:0]         wrAddr,
  input logic [DATA_W-1:0]         wrData,
  input logic                      updatePulse,
  input logic [NUM_CH-1:0]         chanEn,
  input logic [NUM_CH*TUNE_W-1:0]  shadowTune,
  input logic [NUM_CH*PHASE_W-1:0] shadowPhase,
  input logic [NUM_CH*TUNE_W-1:0]  tuneActive,
  input logic [NUM_CH*PHASE_W-1:0] phaseActive
);
  localparam logic [ADDR_W-1:0] SelA   = ADDR_W'(SEL_ADDR);
  localparam logic [ADDR_W-1:0] TuneA  = ADDR_W'(TUNE_ADDR);
  localparam logic [ADDR_W-1:0] PhaseA = ADDR_W'(PHASE_ADDR);

  logic unmapped;
  assign unmapped = wrEn && (wrAddr != SelA) && (wrAddr != TuneA) && (wrAddr != PhaseA);

  AST_SEL_IMMEDIATE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == SelA) |=> (chanEn == $past(wrData[NUM_CH-1:0]))); // R2

  AST_TUNE_FANOUT: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == TuneA && chanEn == {NUM_CH{1'b1}})
      |=> (shadowTune == {NUM_CH{$past(wrData[TUNE_W-1:0])}})); // R3

  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && chanEn == '0 && wrAddr != SelA)
      |=> ($stable(shadowTune) && $stable(shadowPhase))); // R5

  AST_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    !updatePulse |=> ($stable(tuneActive) && $stable(phaseActive))); // R7

  AST_UPDATE_OLD_SHADOW: assert property (@(posedge clk) disable iff (!rstN)
    updatePulse |=> (tuneActive == $past(shadowTune) && phaseActive == $past(shadowPhase))); // R8

  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    unmapped |=> ($stable(chanEn) && $stable(shadowTune) && $stable(shadowPhase))); // R9
endmodule

bind dual_chan_regs dcr_checker #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TUNE_W(TUNE_W),
  .PHASE_W(PHASE_W), .SEL_ADDR(SEL_ADDR), .TUNE_ADDR(TUNE_ADDR),
  .PHASE_ADDR(PHASE_ADDR)
) chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .updatePulse(updatePulse), .chanEn(chanEn), .shadowTune(shadowTune),
  .shadowPhase(shadowPhase), .tuneActive(tuneActive), .phaseActive(phaseActive)
);

// File: tb/dual_chan_regs_tb_top.sv
module dual_chan_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        updatePulse = 1'b0;
  logic [63:0] tuneActive;
  logic [27:0] phaseActive;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_chan_regs dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .updatePulse(updatePulse),
    .tuneActive(tuneActive), .phaseActive(phaseActive)
  );

  // behavioural reference state
  bit [1:0]  mEn;
  bit [31:0] mTune [2];
  bit [13:0] mPhase [2];
  bit [31:0] mTuneAct [2];
  bit [13:0] mPhaseAct [2];

  task automatic modelReset();
    mEn = 2'b11;
    for (int c = 0; c < 2; c++) begin
      mTune[c] = 0; mPhase[c] = 0; mTuneAct[c] = 0; mPhaseAct[c] = 0;
    end
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      bit [1:0] enNow;
      enNow = mEn;
      if (updatePulse)
        for (int c = 0; c < 2; c++) begin
          mTuneAct[c] = mTune[c]; mPhaseAct[c] = mPhase[c];
        end
      if (wrEn) begin
        if (wrAddr == 8'h00) mEn = wrData[1:0];
        for (int c = 0; c < 2; c++) if (enNow[c]) begin
          if (wrAddr == 8'h04) mTune[c] = wrData;
          if (wrAddr == 8'h05) mPhase[c] = wrData[13:0];
        end
      end
    end
  end

  function automatic bit [31:0] expRead(input bit [7:0] a);
    int lo;
    lo = mEn[0] ? 0 : (mEn[1] ? 1 : -1);
    if (a == 8'h00) return {30'd0, mEn};
    if (a == 8'h04) return (lo < 0) ? 32'd0 : mTune[lo];
    if (a == 8'h05) return (lo < 0) ? 32'd0 : {18'd0, mPhase[lo]};
    return 32'd0;
  endfunction

  task automatic check(input string tag, input string what, input bit [63:0] act, input bit [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    check(tag, "tuneActive", 64'(tuneActive), {mTuneAct[1], mTuneAct[0]});
    check(tag, "phaseActive", 64'(phaseActive), 64'({mPhaseAct[1], mPhaseAct[0]}));
    check(tag, "rdData", 64'(rdData), 64'(expRead(rdAddr)));
  endtask

  task automatic step(input bit we, input bit [7:0] wa, input bit [31:0] wd,
                      input bit [7:0] ra, input bit up, input string tag);
    @(negedge clk);
    wrEn = we; wrAddr = wa; wrData = wd; rdAddr = ra; updatePulse = up;
    #1 compareAll(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1 reset state, read the mask and words while in reset
    step(0, 8'h00, 0, 8'h00, 0, "R1");
    step(0, 8'h00, 0, 8'h04, 0, "R1");
    step(0, 8'h00, 0, 8'h05, 0, "R1");
    @(negedge clk); rstN = 1'b1;
    step(0, 8'h00, 0, 8'h00, 0, "R1");
    // R3 broadcast write, R7 no update yet
    step(1, 8'h04, 32'h1111_1111, 8'h04, 0, "R3");
    step(0, 8'h00, 0, 8'h04, 0, "R7");
    step(1, 8'h00, 32'h0, 8'h04, 1, "R7");
    step(0, 8'h00, 0, 8'h04, 0, "R7");
    // R2 R10 per-channel sequence
    step(1, 8'h00, 32'h1, 8'h00, 0, "R2");
    step(1, 8'h04, 32'hAAAA_0001, 8'h00, 0, "R10");
    step(1, 8'h05, 32'hFFFF_C123, 8'h04, 0, "R4");
    step(1, 8'h00, 32'h2, 8'h05, 0, "R2");
    step(1, 8'h04, 32'hBBBB_0002, 8'h04, 0, "R10");
    step(1, 8'h05, 32'h0000_2abc, 8'h04, 0, "R6");
    step(0, 8'h00, 0, 8'h05, 0, "R6");
    step(1, 8'h00, 32'h3, 8'h04, 1, "R7");
    step(0, 8'h00, 0, 8'h04, 0, "R6");
    step(0, 8'h00, 0, 8'h05, 0, "R6");
    // R5 empty mask
    step(1, 8'h00, 32'h0, 8'h00, 0, "R5");
    step(1, 8'h04, 32'hDEAD_BEEF, 8'h04, 0, "R5");
    step(1, 8'h05, 32'h0000_1FFF, 8'h05, 1, "R5");
    step(0, 8'h00, 0, 8'h04, 0, "R5");
    // R9 unmapped
    step(1, 8'h00, 32'h3, 8'h00, 0, "R9");
    step(1, 8'h07, 32'h1234_5678, 8'h06, 0, "R9");
    step(1, 8'h01, 32'h0, 8'h00, 0, "R9");
    step(0, 8'h00, 0, 8'h04, 0, "R9");
    // R8 update and write on the same edge
    step(1, 8'h04, 32'h5555_6666, 8'h04, 1, "R8");
    step(0, 8'h00, 0, 8'h04, 0, "R8");
    step(0, 8'h00, 0, 8'h04, 1, "R8");
    step(0, 8'h00, 0, 8'h04, 0, "R8");
    // mixed stream R2 R3 R4 R6 R7 R8
    for (int i = 0; i < 400; i++) begin
      bit [7:0] addrs [4];
      addrs[0] = 8'h00; addrs[1] = 8'h04; addrs[2] = 8'h05; addrs[3] = 8'h09;
      step(bit'($urandom_range(0, 1)), addrs[$urandom_range(0, 3)], $urandom(),
           addrs[$urandom_range(0, 3)], ($urandom_range(0, 3) == 0), "R3_R8_mix");
    end
    @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule